// File: doc/BRIEF.md
# Bus Transaction Queue with Snoop Reservation

This block holds the transactions of a processor bus interface that have finished their address phase but still wait for their data phase. It has six slots by default. Two sources fill it: the core, which posts its own bus transactions, and the snoop path, which must push modified data back when another master hits a dirty line. Data phases on the bus finish in the order the address phases were issued. So the queue is a first-in first-out ring, and each data-phase-complete pulse retires the oldest slot.

When every slot is taken, a snoop push cannot be stored and is answered with a retry. The retry repeats on every attempt until some data phase completes. If the core can take all the slots, a system that refuses to finish the core's data phases until the snoop completes will deadlock. A 3-bit configuration input set to 001 keeps the last slot for snoop pushes only, so the core can hold at most five slots. Any other value shares every slot.

A small state machine classifies the fill level. It has four states: EMPTY (no slots used), OPEN (at least one slot used and at least two free), LAST (exactly one slot free) and FULL. Its transitions are: EMPTY to OPEN on an allocation; OPEN to LAST on an allocation that leaves one slot free; OPEN to EMPTY when the only entry retires; LAST to FULL on an allocation; LAST to OPEN on a retire; FULL to LAST on a retire. An allocation and a retire in the same cycle keep the current state. The output decode of the state gives two room signals, one for snoops and one for the core. The core's room signal is cleared in LAST while the reservation is on.

Top module: `bus_txn_queue`

## Requirements
- R1: After reset, occupancy is 0, head_valid is 0, snp_retry is 0 and core_accept is 0. Occupancy never exceeds six with the default depth.
- R2: Entries leave in arrival order. head_data always shows the oldest entry. A high dten_done removes it at the clock edge. dten_done while the queue is empty has no effect.
- R3: A snoop request (snp_valid=1) that finds all six slots used raises snp_retry in the same cycle, and nothing is stored. The retry repeats for every attempt until an entry retires. The next snoop attempt after that is stored.
- R4: With cfg_resv = 3'b001, a core request is accepted only while occupancy is below five. A snoop push may still take the sixth slot.
- R5: With any cfg_resv value other than 3'b001 (000, 010 and the rest), there is no reservation, and the core can fill all six slots.
- R6: core_full is 1 exactly when occupancy has reached the core limit: five with cfg_resv = 3'b001, six otherwise.
- R7: When snp_valid and core_valid are both high and the snoop is not retried, the snoop payload is stored and core_accept is 0.
- R8: An allocation and a retire in the same cycle leave occupancy unchanged.
- R9: head_snoop is 1 when the oldest entry came from the snoop port and 0 when it came from the core.
- R10: Admission uses the occupancy at the start of the cycle. A snoop arriving at a full queue in the same cycle as a retire is still retried.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_resv | input | 3 | Reservation control; 3'b001 keeps one slot for snoops |
| core_valid | input | 1 | Core transaction offered this cycle |
| core_data | input | 8 | Core transaction descriptor |
| core_accept | output | 1 | Core transaction taken at this edge |
| snp_valid | input | 1 | Snoop push offered this cycle |
| snp_data | input | 8 | Snoop push descriptor |
| snp_retry | output | 1 | Snoop push refused; retry the snooped transaction |
| dten_done | input | 1 | Oldest entry's data phase has completed |
| head_valid | output | 1 | Queue holds at least one entry |
| head_data | output | 8 | Descriptor of the oldest entry |
| head_snoop | output | 1 | Oldest entry is a snoop push |
| occupancy | output | 3 | Number of entries held |
| core_full | output | 1 | No slot left for core requests |

## Verification
The hardest case to reach is a sixth slot held by a snoop push while the reservation is on, followed by repeated snoop retries. These come first in a run of single pushes, then in the same cycle as a retire, and then with the reservation turned off while the core already holds six entries. Random traffic seldom gets there, because retires drain the queue faster than core requests fill it. Directed sequences therefore fill the queue with core traffic up to the limit, add a snoop push on top, and keep snooping while retires are held back. Seeded random traffic follows, with a low retire rate and the configuration changing every 64 cycles, so the queue stays near its limits under both settings.

// File: rtl/txq_pkg.sv
package txq_pkg;

    // Fill-level classes tracked by the admission state machine
    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_OPEN  = 2'd1,
        OCC_LAST  = 2'd2,
        OCC_FULL  = 2'd3
    } occ_state_e;

    // Configuration code that keeps one slot for snoop pushes
    localparam logic [2:0] RESV_ONE_CODE = 3'b001;

endpackage

// File: rtl/txq_ctrl.sv
module txq_ctrl
    import txq_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int CFG_W = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_resv,
    input  logic             core_valid,
    input  logic             snp_valid,
    input  logic             pop_req,
    output logic             core_accept,
    output logic             snp_accept,
    output logic             snp_retry,
    output logic             pop_fire,
    output logic [CNT_W-1:0] occupancy,
    output logic             core_full,
    output logic             not_empty
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] PRE_CNT  = CNT_W'(DEPTH - 2);
    localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

    occ_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             resv_on;
    logic             room_any, room_core;
    logic             alloc;

    assign resv_on = (cfg_resv == CFG_W'(RESV_ONE_CODE));

    // Output decode of the fill-level state
    always_comb begin
        room_any  = 1'b0;
        room_core = 1'b0;
        unique case (st_q)
            OCC_EMPTY: begin room_any = 1'b1; room_core = 1'b1;     end
            OCC_OPEN:  begin room_any = 1'b1; room_core = 1'b1;     end
            OCC_LAST:  begin room_any = 1'b1; room_core = !resv_on; end
            OCC_FULL:  begin room_any = 1'b0; room_core = 1'b0;     end
            default:   begin room_any = 1'b0; room_core = 1'b0;     end
        endcase
    end

    // Snoop push has priority; a single write per cycle
    assign snp_accept  = snp_valid && room_any;
    assign snp_retry   = snp_valid && !room_any;
    assign core_accept = core_valid && !snp_valid && room_core;
    assign alloc       = snp_accept || core_accept;
    assign pop_fire    = pop_req && (st_q != OCC_EMPTY);
    assign core_full   = !room_core;
    assign not_empty   = (st_q != OCC_EMPTY);
    assign occupancy   = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        unique case ({alloc, pop_fire})
            2'b10:   cnt_d = cnt_q + 1'b1;
            2'b01:   cnt_d = cnt_q - 1'b1;
            default: cnt_d = cnt_q;
        endcase
    end

    // Next-state transitions (DEPTH of at least 3 assumed)
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            OCC_EMPTY: if (alloc) st_d = OCC_OPEN;
            OCC_OPEN: begin
                if (alloc && !pop_fire && cnt_q == PRE_CNT)
                    st_d = OCC_LAST;
                else if (pop_fire && !alloc && cnt_q == ONE_CNT)
                    st_d = OCC_EMPTY;
            end
            OCC_LAST: begin
                if (alloc && !pop_fire)
                    st_d = OCC_FULL;
                else if (pop_fire && !alloc)
                    st_d = OCC_OPEN;
            end
            OCC_FULL: if (pop_fire && !alloc) st_d = OCC_LAST;
            default:  st_d = OCC_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= OCC_EMPTY;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT); // R1
    AST_FULL_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == OCC_FULL) == (cnt_q == FULL_CNT)); // R1
    AST_LAST_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == OCC_LAST) == (cnt_q == LAST_CNT)); // R6
    AST_RETRY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        snp_retry |-> cnt_q == FULL_CNT); // R3
    AST_RETRY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_retry && !pop_req) |=> (cnt_q == FULL_CNT)); // R10

endmodule

// File: rtl/txq_store.sv
module txq_store #(
    parameter int DEPTH  = 6,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_snoop,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_snoop
);

    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [DATA_W-1:0] data_q [DEPTH];
    logic [DEPTH-1:0]  snoop_q;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (wr_en) wr_ptr_q <= ptr_step(wr_ptr_q);
            if (rd_en) rd_ptr_q <= ptr_step(rd_ptr_q);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q[i]  <= '0;
                snoop_q[i] <= 1'b0;
            end else if (wr_en && wr_ptr_q == PTR_W'(i)) begin
                data_q[i]  <= wr_data;
                snoop_q[i] <= wr_snoop;
            end
        end
    end

    assign rd_data  = data_q[rd_ptr_q];
    assign rd_snoop = snoop_q[rd_ptr_q];

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr_q <= LAST_IDX) && (rd_ptr_q <= LAST_IDX)); // R2

endmodule

// File: rtl/bus_txn_queue.sv
module bus_txn_queue #(
    parameter int DEPTH  = 6,
    parameter int DATA_W = 8,
    parameter int CFG_W  = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CFG_W-1:0]  cfg_resv,
    input  logic              core_valid,
    input  logic [DATA_W-1:0] core_data,
    output logic              core_accept,
    input  logic              snp_valid,
    input  logic [DATA_W-1:0] snp_data,
    output logic              snp_retry,
    input  logic              dten_done,
    output logic              head_valid,
    output logic [DATA_W-1:0] head_data,
    output logic              head_snoop,
    output logic [CNT_W-1:0]  occupancy,
    output logic              core_full
);

    logic snp_accept;
    logic pop_fire;
    logic wr_en;

    txq_ctrl #(.DEPTH(DEPTH), .CFG_W(CFG_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_resv   (cfg_resv),
        .core_valid (core_valid),
        .snp_valid  (snp_valid),
        .pop_req    (dten_done),
        .core_accept(core_accept),
        .snp_accept (snp_accept),
        .snp_retry  (snp_retry),
        .pop_fire   (pop_fire),
        .occupancy  (occupancy),
        .core_full  (core_full),
        .not_empty  (head_valid)
    );

    assign wr_en = snp_accept || core_accept;

    txq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (snp_accept ? snp_data : core_data),
        .wr_snoop(snp_accept),
        .rd_en   (pop_fire),
        .rd_data (head_data),
        .rd_snoop(head_snoop)
    );

    AST_CORE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (core_accept && cfg_resv == CFG_W'(txq_pkg::RESV_ONE_CODE))
            |-> occupancy < CNT_W'(DEPTH - 1)); // R4
    AST_FULL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        core_full |-> !core_accept); // R6
    AST_SNOOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !snp_retry) |-> !core_accept); // R7
    AST_ALLOC_FREE_BAL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dten_done && head_valid) |=> $stable(occupancy)); // R8
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (!head_valid && dten_done && !wr_en) |=> (occupancy == '0)); // R2

endmodule

// File: tb/bus_txn_queue_bench.sv
module bus_txn_queue_bench;

    localparam int N = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] cfg_resv = '0;
    logic       core_valid = 1'b0;
    logic [7:0] core_data = '0;
    logic       snp_valid = 1'b0;
    logic [7:0] snp_data = '0;
    logic       dten_done = 1'b0;
    logic       core_accept, snp_retry, head_valid, head_snoop, core_full;
    logic [7:0] head_data;
    logic [2:0] occupancy;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // Reference model
    int         mcnt = 0;
    logic [7:0] mdata [N];
    bit         msnp  [N];

    always #5 clk = ~clk;

    bus_txn_queue u_bus_txn_queue (
        .clk(clk), .rst_n(rst_n), .cfg_resv(cfg_resv),
        .core_valid(core_valid), .core_data(core_data), .core_accept(core_accept),
        .snp_valid(snp_valid), .snp_data(snp_data), .snp_retry(snp_retry),
        .dten_done(dten_done), .head_valid(head_valid), .head_data(head_data),
        .head_snoop(head_snoop), .occupancy(occupancy), .core_full(core_full)
    );

    function automatic int core_limit(input logic [2:0] cfg);
        return (cfg == 3'b001) ? N - 1 : N;
    endfunction

    function automatic bit exp_retry(input bit sv, input int cnt);
        return sv && (cnt == N);
    endfunction

    function automatic bit exp_core(input bit cv, input bit sv, input int cnt, input logic [2:0] cfg);
        return cv && !sv && (cnt < core_limit(cfg));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input bit cv, input logic [7:0] cd, input bit sv,
                        input logic [7:0] sd, input bit pop, input logic [2:0] cfg);
        bit e_retry, e_core, e_snp;
        core_valid = cv; core_data = cd; snp_valid = sv; snp_data = sd;
        dten_done = pop; cfg_resv = cfg;
        #1;
        e_retry = exp_retry(sv, mcnt);
        e_snp   = sv && !e_retry;
        e_core  = exp_core(cv, sv, mcnt, cfg);
        chk(int'(occupancy) == mcnt, "R1 R8 occupancy", int'(occupancy), mcnt);
        chk(head_valid == (mcnt > 0), "R1 R2 head_valid", int'(head_valid), int'(mcnt > 0));
        if (mcnt > 0) begin
            chk(head_data == mdata[0], "R2 head_data", int'(head_data), int'(mdata[0]));
            chk(head_snoop == msnp[0], "R9 head_snoop", int'(head_snoop), int'(msnp[0]));
        end
        chk(core_accept == e_core, "R4 R5 R7 core_accept", int'(core_accept), int'(e_core));
        chk(snp_retry == e_retry, "R3 R10 snp_retry", int'(snp_retry), int'(e_retry));
        chk(core_full == (mcnt >= core_limit(cfg)), "R6 core_full",
            int'(core_full), int'(mcnt >= core_limit(cfg)));
        @(posedge clk);
        if (pop && mcnt > 0) begin
            for (int i = 0; i < N - 1; i++) begin
                mdata[i] = mdata[i+1];
                msnp[i]  = msnp[i+1];
            end
            mcnt--;
        end
        if (e_snp) begin
            mdata[mcnt] = sd; msnp[mcnt] = 1'b1; mcnt++;
        end else if (e_core) begin
            mdata[mcnt] = cd; msnp[mcnt] = 1'b0; mcnt++;
        end
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            mdata[i] = '0; msnp[i] = 1'b0;
        end
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        // R1: reset state observed while reset is held
        chk(occupancy == 3'd0 && !head_valid && !snp_retry && !core_accept,
            "R1 reset outputs", int'(occupancy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        step(0, 8'h00, 0, 8'h00, 0, 3'b001);

        // R4: reservation on, core fills five slots then is held off
        for (int i = 0; i < 5; i++) step(1, 8'h10 + 8'(i), 0, 8'h00, 0, 3'b001);
        step(1, 8'h1F, 0, 8'h00, 0, 3'b001);
        // R4: snoop still takes the reserved sixth slot
        step(0, 8'h00, 1, 8'hA0, 0, 3'b001);
        // R3: repeated retries while full
        for (int i = 0; i < 3; i++) step(1, 8'h20, 1, 8'hA1, 0, 3'b001);
        // R10: retire in the same cycle still retries
        step(0, 8'h00, 1, 8'hA2, 1, 3'b001);
        // R3: after the retire the snoop is accepted
        step(0, 8'h00, 1, 8'hA3, 0, 3'b001);
        // R2 R9: drain in order, then retire on empty
        for (int i = 0; i < 8; i++) step(0, 8'h00, 0, 8'h00, 1, 3'b001);

        // R5: no reservation, core fills all six
        for (int i = 0; i < 7; i++) step(1, 8'h40 + 8'(i), 0, 8'h00, 0, 3'b000);
        step(0, 8'h00, 1, 8'hB0, 0, 3'b000);
        step(0, 8'h00, 0, 8'h00, 1, 3'b010);
        // R8: allocate and retire in one cycle
        step(1, 8'h55, 0, 8'h00, 1, 3'b010);
        // R6: switching reservation on with five held raises core_full
        step(1, 8'h56, 0, 8'h00, 0, 3'b001);
        // R7: snoop and core together
        step(0, 8'h00, 0, 8'h00, 1, 3'b000);
        step(1, 8'h60, 1, 8'hC0, 0, 3'b000);
        for (int i = 0; i < 7; i++) step(0, 8'h00, 0, 8'h00, 1, 3'b000);

        // Seeded random traffic
        begin
            logic [2:0] rcfg = 3'b001;
            for (int c = 0; c < 3000; c++) begin
                if (c % 64 == 0) rcfg = 3'($urandom_range(0, 2));
                step(($urandom % 100) < 60, 8'($urandom), ($urandom % 100) < 25,
                     8'($urandom), ($urandom % 100) < 30, rcfg);
            end
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule